// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a set of access rights, or into a fault code. Each request carries the virtual address, the accesses it needs (read, write, execute), a privilege mode index and the physical base address of the top-level table. The block settles three cases without going to memory. A physical-access request passes through unchanged. An address that is not a proper sign extension is rejected. A kernel superpage window is mapped with a fixed bit relocation. Every other address is resolved by walking a three-level table.

The walk reads 64-bit table entries through a read port. The port issues a one-cycle request with an address and waits for a response with data. Only one read is ever in flight. Each level takes a 10-bit index from the virtual address; the page size is 8 KiB. Each entry supplies the next table base, or the page frame, from its upper half. At the last level, the permission bit for the given mode is selected by shifting with the mode index. Fault-on-operation bits then remove rights again and produce their own fault codes. The result is registered and flagged by a one-cycle done pulse. A new request is accepted in that same cycle.

Top module: `pgwalk_top`

## Requirements
- R1: With `req_bypass` high, the request completes on the next cycle with `res_paddr` equal to `req_vaddr`, `res_prot` = 3'b111, `res_code` = 0, and no memory read.
- R2: A non-bypass address whose bits [63:43] are not all equal completes on the next cycle with `res_code` = 1 (access violation) and no memory read.
- R3: A canonical address with bit 63 set and bits [42:41] = 2'b10 is a superpage. In mode 0 it completes with code 0, prot 3'b111 and a physical address holding virtual bits [39:0] in place and virtual bit 40 at bit 43. In any other mode it gives code 1. There is no memory read in either case.
- R4: A walk issues reads at base + index*8. The indices are virtual bits [42:33], [32:23] and [22:13] for levels 1, 2 and 3. Level 1 uses `pt_base`; each later base is entry bits [63:32] shifted left by 13.
- R5: An entry with bit 0 (valid) clear, at any level, ends the walk at that level with code 2 (not valid). On every fault, `res_prot` and `res_paddr` are zero.
- R6: A valid level-1 or level-2 entry with bit 8 (kernel read) clear ends the walk with code 1.
- R7: At level 3, read and execute are granted by entry bit 8+mode, and write by bit 12+mode. If a non-empty need shares no bit with the granted set, the code is 1. The prot encoding is bit 0 read, bit 1 write, bit 2 execute; `req_need` uses the same encoding.
- R8: The granted set is then masked by entry bits 1, 2 and 3, which block read, write and execute respectively. If a non-empty need then shares no bit with the result, the code is 5 when execute is needed, else 4 when write is needed, else 3. On success, `res_prot` is the masked set and `res_paddr` is (entry[63:32] << 13) | vaddr[12:0].
- R9: An empty need never faults at level 3 once the entry is valid. The result is code 0 with the masked rights, which may be empty.
- R10: After reset the block is idle with no read. At most one read is outstanding at a time. `req_valid` while busy is ignored and produces no extra done.
- R11: A request presented in the cycle that `done` is high is accepted, so translations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a translation (accepted when idle) |
| req_bypass | input | 1 | Physical-access request |
| req_mode | input | 2 | Privilege mode index, 0 = kernel |
| req_need | input | 3 | Needed accesses: bit0 read, bit1 write, bit2 execute |
| req_vaddr | input | 64 | Virtual address |
| pt_base | input | 64 | Physical base of the level-1 table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | Result valid pulse |
| res_code | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |
| res_paddr | output | 64 | Physical address |
| res_prot | output | 3 | Granted accesses |

## Verification
Finishing one translation and accepting the next can happen in the same cycle. The bench provokes this by watching for `done` and raising `req_valid` straight away. It does this with a walk followed by a superpage followed by another walk. The scoreboard then requires each result to match its own request in order. It also requires the read log of each result to hold only that request's table reads. A request pulsed in the middle of a walk checks the opposite case: it must leave no result behind.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the page table walker: fault codes, access bits
// and the positions of control bits inside a table entry.
package pgwalk_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } flt_e;

    // access / protection bit positions
    localparam int ACC_RD = 0;
    localparam int ACC_WR = 1;
    localparam int ACC_EX = 2;

    // entry control bits
    localparam int PTE_V   = 0;
    localparam int PTE_FOR = 1;
    localparam int PTE_FOW = 2;
    localparam int PTE_FOE = 3;
    localparam int PTE_KRE = 8;
    localparam int PTE_KWE = 12;

    localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/pgwalk_front.sv
`timescale 1ns/1ps
// Front decoder: settles requests that need no table read (physical
// bypass, non-canonical address, kernel superpage window).
// Assumes: combinational, evaluated on the raw request inputs.
module pgwalk_front
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 43,
    parameter int SP_SRC  = 40,
    parameter int SP_DST  = 43
) (
    input  logic              bypass,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] vaddr,
    output logic              hit,
    output flt_e              code,
    output logic [ADDR_W-1:0] paddr,
    output logic [2:0]        prot
);
    localparam int HI_W = ADDR_W - VA_BITS;

    logic              canon;
    logic              super_win;
    logic [ADDR_W-1:0] sp_pa;

    assign canon     = (vaddr[ADDR_W-1:VA_BITS] == {HI_W{vaddr[ADDR_W-1]}});
    assign super_win = vaddr[ADDR_W-1] && (vaddr[VA_BITS-1:VA_BITS-2] == 2'b10);

    // Superpage relocation: low bits in place, one bit moved upward.
    always_comb begin
        sp_pa             = '0;
        sp_pa[SP_SRC-1:0] = vaddr[SP_SRC-1:0];
        sp_pa[SP_DST]     = vaddr[SP_SRC];
    end

    // Priority decode of the shortcut cases.
    always_comb begin
        hit   = 1'b0;
        code  = FLT_NONE;
        paddr = '0;
        prot  = '0;
        if (bypass) begin
            hit   = 1'b1;
            paddr = vaddr;
            prot  = 3'b111;
        end else if (!canon) begin
            hit  = 1'b1;
            code = FLT_ACV;
        end else if (super_win) begin
            hit = 1'b1;
            if (mode != MODE_KERNEL) begin
                code = FLT_ACV;
            end else begin
                paddr = sp_pa;
                prot  = 3'b111;
            end
        end
    end

endmodule

// File: rtl/pgwalk_index.sv
`timescale 1ns/1ps
// Entry address generator: picks the index field for a level and adds
// it, scaled by the entry size, to the table base.
// Assumes: level 0 takes the most significant index field.
module pgwalk_index #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3,
    parameter int ENT_SHIFT = 3,
    parameter int LVL_W     = $clog2(LEVELS)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] addr
);
    logic [IDX_BITS-1:0] idx_at [LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_fld
        assign idx_at[g] = vaddr[PAGE_BITS + (LEVELS-1-g)*IDX_BITS +: IDX_BITS];
    end

    // Select the index field of the requested level.
    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) idx_sel = idx_at[i];
        end
    end

    assign addr = base + (ADDR_W'(idx_sel) << ENT_SHIFT);

endmodule

// File: rtl/pgwalk_leaf.sv
`timescale 1ns/1ps
// Last-level evaluator: per-mode permission selection, access-violation
// check, fault-on-operation masking and physical address assembly.
// Assumes: combinational on the returned entry.
module pgwalk_leaf
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PTE_W     = 64,
    parameter int PAGE_BITS = 13,
    parameter int FRAME_LSB = 32
) (
    input  logic [PTE_W-1:0]     pte,
    input  logic [1:0]           mode,
    input  logic [2:0]           need,
    input  logic [PAGE_BITS-1:0] offs,
    output flt_e                 code,
    output logic [2:0]           prot,
    output logic [ADDR_W-1:0]    paddr
);
    logic              rx_ok;
    logic              wr_ok;
    logic [2:0]        granted;
    logic [2:0]        blocked;
    logic [2:0]        kept;
    logic [ADDR_W-1:0] frame_pa;

    assign rx_ok    = pte[PTE_KRE + 32'(mode)];
    assign wr_ok    = pte[PTE_KWE + 32'(mode)];
    assign granted  = {rx_ok, wr_ok, rx_ok};
    assign blocked  = {pte[PTE_FOE], pte[PTE_FOW], pte[PTE_FOR]};
    assign kept     = granted & ~blocked;
    assign frame_pa = (ADDR_W'(pte[PTE_W-1:FRAME_LSB]) << PAGE_BITS) | ADDR_W'(offs);

    // Ordered checks: valid, permission, fault-on with exec > write > read.
    always_comb begin
        code  = FLT_NONE;
        prot  = kept;
        paddr = frame_pa;
        if (!pte[PTE_V]) begin
            code = FLT_TNV;
        end else if (need != 3'b000 && (granted & need) == 3'b000) begin
            code = FLT_ACV;
        end else if (need != 3'b000 && (kept & need) == 3'b000) begin
            if (need[ACC_EX])      code = FLT_FOE;
            else if (need[ACC_WR]) code = FLT_FOW;
            else                   code = FLT_FOR;
        end
        if (code != FLT_NONE) begin
            prot  = '0;
            paddr = '0;
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
// Three-level page table walker. Shortcut cases finish one cycle after
// acceptance; walks issue one read per level, one at a time, and finish
// one cycle after the deciding response. done is a single-cycle pulse
// and the block is idle in that cycle, ready for the next request.
// Assumes: the memory answers every request exactly once.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PTE_W     = 64,
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3,
    parameter int FRAME_LSB = 32,
    parameter int SP_SRC    = 40,
    parameter int SP_DST    = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_bypass,
    input  logic [1:0]        req_mode,
    input  logic [2:0]        req_need,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] pt_base,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic [2:0]        res_code,
    output logic [ADDR_W-1:0] res_paddr,
    output logic [2:0]        res_prot
);
    localparam int LVL_W = $clog2(LEVELS);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e               state;
    logic [LVL_W-1:0]  lvl_q;
    logic [ADDR_W-1:0] va_q;
    logic [2:0]        need_q;
    logic [1:0]        mode_q;

    logic              fr_hit;
    flt_e              fr_code;
    logic [ADDR_W-1:0] fr_paddr;
    logic [2:0]        fr_prot;

    flt_e              lf_code;
    logic [2:0]        lf_prot;
    logic [ADDR_W-1:0] lf_paddr;

    logic [ADDR_W-1:0] next_base;
    logic [ADDR_W-1:0] ix_base;
    logic [ADDR_W-1:0] ix_va;
    logic [LVL_W-1:0]  ix_lvl;
    logic [ADDR_W-1:0] ix_addr;

    assign busy      = (state != ST_IDLE);
    assign next_base = ADDR_W'(mem_rsp_data[PTE_W-1:FRAME_LSB]) << PAGE_BITS;
    assign ix_base   = busy ? next_base : pt_base;
    assign ix_va     = busy ? va_q : req_vaddr;
    assign ix_lvl    = busy ? lvl_q + LVL_W'(1) : '0;

    pgwalk_front #(
        .ADDR_W (ADDR_W), .VA_BITS(VA_BITS), .SP_SRC(SP_SRC), .SP_DST(SP_DST)
    ) i_front (
        .bypass (req_bypass),
        .mode   (req_mode),
        .vaddr  (req_vaddr),
        .hit    (fr_hit),
        .code   (fr_code),
        .paddr  (fr_paddr),
        .prot   (fr_prot)
    );

    pgwalk_index #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS),
        .LEVELS(LEVELS), .ENT_SHIFT($clog2(PTE_W / 8)), .LVL_W(LVL_W)
    ) i_index (
        .base  (ix_base),
        .vaddr (ix_va),
        .lvl   (ix_lvl),
        .addr  (ix_addr)
    );

    pgwalk_leaf #(
        .ADDR_W(ADDR_W), .PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS), .FRAME_LSB(FRAME_LSB)
    ) i_leaf (
        .pte   (mem_rsp_data),
        .mode  (mode_q),
        .need  (need_q),
        .offs  (va_q[PAGE_BITS-1:0]),
        .code  (lf_code),
        .prot  (lf_prot),
        .paddr (lf_paddr)
    );

    // Walk sequencer, read issue and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lvl_q     <= '0;
            va_q      <= '0;
            need_q    <= '0;
            mode_q    <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            done      <= 1'b0;
            res_code  <= '0;
            res_paddr <= '0;
            res_prot  <= '0;
        end else begin
            done    <= 1'b0;
            mem_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        need_q <= req_need;
                        mode_q <= req_mode;
                        if (fr_hit) begin
                            done      <= 1'b1;
                            res_code  <= fr_code;
                            res_paddr <= fr_paddr;
                            res_prot  <= fr_prot;
                        end else begin
                            mem_req  <= 1'b1;
                            mem_addr <= ix_addr;
                            lvl_q    <= '0;
                            state    <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (lvl_q == LAST) begin
                            done      <= 1'b1;
                            res_code  <= lf_code;
                            res_paddr <= lf_paddr;
                            res_prot  <= lf_prot;
                            state     <= ST_IDLE;
                        end else if (!mem_rsp_data[PTE_V] || !mem_rsp_data[PTE_KRE]) begin
                            done      <= 1'b1;
                            res_code  <= mem_rsp_data[PTE_V] ? FLT_ACV : FLT_TNV;
                            res_paddr <= '0;
                            res_prot  <= '0;
                            state     <= ST_IDLE;
                        end else begin
                            mem_req  <= 1'b1;
                            mem_addr <= ix_addr;
                            lvl_q    <= lvl_q + LVL_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgwalk_chk.sv
`timescale 1ns/1ps
// Protocol and result checker for pgwalk_top, attached by bind.
// Assumes: synchronous active-low reset; checks start one cycle after reset.
module pgwalk_chk #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 43
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_bypass,
    input logic [1:0]        req_mode,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic [2:0]        res_code,
    input logic [ADDR_W-1:0] res_paddr,
    input logic [2:0]        res_prot
);
    logic live;
    logic outst;
    logic noncanon;
    logic superwin;
    logic take;

    assign noncanon = (req_vaddr[ADDR_W-1:VA_BITS] != {(ADDR_W-VA_BITS){req_vaddr[ADDR_W-1]}});
    assign superwin = req_vaddr[ADDR_W-1] && req_vaddr[VA_BITS-1:VA_BITS-2] == 2'b10;
    assign take     = req_valid && !busy;

    // Track reset history and the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= 1'b0;
            outst <= 1'b0;
        end else begin
            live <= 1'b1;
            if (mem_req) outst <= 1'b1;
            else if (mem_rsp_valid) outst <= 1'b0;
        end
    end

    AST_ONE_READ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outst); // R10

    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R10

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_code != 3'd0) |-> (res_prot == 3'd0 && res_paddr == '0)); // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(take && req_bypass)) |->
        (done && res_code == 3'd0 && res_prot == 3'b111 && res_paddr == $past(req_vaddr))); // R1

    AST_NONCANON_ACV: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(take && !req_bypass && noncanon)) |-> (done && res_code == 3'd1)); // R2

    AST_SUPER_USER_ACV: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(take && !req_bypass && !noncanon && superwin && req_mode != 2'd0))
        |-> (done && res_code == 3'd1)); // R3

endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_bypass    (req_bypass),
    .req_mode      (req_mode),
    .req_vaddr     (req_vaddr),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .res_code      (res_code),
    .res_paddr     (res_paddr),
    .res_prot      (res_prot)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, a monitor pops
// and compares them on each done pulse, and a memory model answers
// table reads two cycles after each request and logs their addresses.
module test_pgwalk_top;

    typedef struct {
        logic [2:0]  code;
        logic [63:0] pa;
        logic [2:0]  prot;
        int          nr;
        logic [63:0] a0;
        logic [63:0] a1;
        logic [63:0] a2;
        string       tag;
    } exp_t;

    localparam logic [63:0] PTB = 64'h10000;
    localparam logic [63:0] L2B = 64'h40000;
    localparam logic [63:0] L3B = 64'h60000;
    localparam logic [15:0] B_V   = 16'h0001;
    localparam logic [15:0] B_FOR = 16'h0002;
    localparam logic [15:0] B_FOW = 16'h0004;
    localparam logic [15:0] B_FOE = 16'h0008;
    localparam logic [15:0] B_KRE = 16'h0100;
    localparam logic [15:0] B_SRE = 16'h0400;
    localparam logic [15:0] B_URE = 16'h0800;
    localparam logic [15:0] B_KWE = 16'h1000;
    localparam logic [15:0] B_UWE = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_bypass = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [2:0]  req_need = 3'd0;
    logic [63:0] req_vaddr = '0;
    logic [63:0] pt_base = PTB;
    logic        busy;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [2:0]  res_code;
    logic [63:0] res_paddr;
    logic [2:0]  res_prot;

    int n_chk = 0;
    int n_fail = 0;
    exp_t        exp_q[$];
    logic [63:0] rd_log[$];
    logic [63:0] pmem [logic [63:0]];
    int          pend = 0;
    logic [63:0] pend_addr = '0;

    always #5 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bypass(req_bypass),
        .req_mode(req_mode), .req_need(req_need), .req_vaddr(req_vaddr),
        .pt_base(pt_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
        .res_code(res_code), .res_paddr(res_paddr), .res_prot(res_prot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] mkva(input int i1, input int i2, input int i3, input int off);
        return {21'd0, i1[9:0], i2[9:0], i3[9:0], off[12:0]};
    endfunction

    function automatic logic [63:0] mkpte(input logic [31:0] frame, input logic [15:0] low);
        return {frame, 16'h0, low};
    endfunction

    // Memory model: answer each read two cycles later, log its address.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            mem_rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pmem.exists(pend_addr) ? pmem[pend_addr] : 64'h0;
                end
            end
            if (rst_n && mem_req) begin
                chk(pend == 0 && !mem_rsp_valid, "R10", "read issued while one in flight",
                    64'(pend), 64'h0);
                pend_addr = mem_addr;
                pend = 2;
                rd_log.push_back(mem_addr);
            end
        end
    end

    // Monitor: compare each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "done with no pending request", 64'h1, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_code == e.code, e.tag, "code", 64'(res_code), 64'(e.code));
                chk(res_paddr == e.pa, e.tag, "paddr", res_paddr, e.pa);
                chk(res_prot == e.prot, e.tag, "prot", 64'(res_prot), 64'(e.prot));
                chk(rd_log.size() == e.nr, "R4", {e.tag, " read count"},
                    64'(rd_log.size()), 64'(e.nr));
                if (rd_log.size() == e.nr) begin
                    if (e.nr > 0) chk(rd_log[0] == e.a0, "R4", {e.tag, " level-1 addr"}, rd_log[0], e.a0);
                    if (e.nr > 1) chk(rd_log[1] == e.a1, "R4", {e.tag, " level-2 addr"}, rd_log[1], e.a1);
                    if (e.nr > 2) chk(rd_log[2] == e.a2, "R4", {e.tag, " level-3 addr"}, rd_log[2], e.a2);
                end
            end
            rd_log.delete();
        end
    end

    task automatic issue_now(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                             input logic byp, input logic [2:0] code, input logic [63:0] pa,
                             input logic [2:0] prot, input int nr, input logic [63:0] a0,
                             input logic [63:0] a1, input logic [63:0] a2, input string tag);
        exp_t e;
        e.code = code; e.pa = pa; e.prot = prot; e.nr = nr;
        e.a0 = a0; e.a1 = a1; e.a2 = a2; e.tag = tag;
        exp_q.push_back(e);
        req_vaddr  = va;
        req_need   = need;
        req_mode   = mode;
        req_bypass = byp;
        req_valid  = 1'b1;
        @(posedge clk);
        #1;
        req_valid  = 1'b0;
        req_bypass = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!done) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic go(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                      input logic byp, input logic [2:0] code, input logic [63:0] pa,
                      input logic [2:0] prot, input int nr, input logic [63:0] a2,
                      input string tag);
        @(posedge clk);
        #1;
        issue_now(va, need, mode, byp, code, pa, prot, nr, PTB + 64'd24, L2B + 64'd40, a2, tag);
        wait_empty();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WDOG", "run did not finish", 64'h0, 64'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        pmem[PTB + 64'd24]       = mkpte(32'h20, B_V | B_KRE);
        pmem[PTB + 64'd40]       = mkpte(32'h21, B_V);
        pmem[L2B + 64'd40]       = mkpte(32'h30, B_V | B_KRE);
        pmem[L2B + 64'd56]       = mkpte(32'h31, B_V);
        pmem[L3B + 64'd7 * 8]    = mkpte(32'h1234, B_V | B_KRE | B_KWE);
        pmem[L3B + 64'd8 * 8]    = mkpte(32'h2000, B_V | B_URE | B_UWE);
        pmem[L3B + 64'd9 * 8]    = mkpte(32'h2001, B_V | B_KRE | B_KWE | B_FOR | B_FOW | B_FOE);
        pmem[L3B + 64'd10 * 8]   = mkpte(32'h2002, B_V | B_KRE | B_KWE | B_FOE);
        pmem[L3B + 64'd12 * 8]   = mkpte(32'h2003, B_V | B_SRE);

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && mem_req == 1'b0, "R10", "reset idle state",
            {61'd0, done, busy, mem_req}, 64'h0);

        // R1 physical bypass, even for a non-canonical address
        go(64'hDEAD_BEEF_0000_1234, 3'b010, 2'd3, 1'b1, 3'd0, 64'hDEAD_BEEF_0000_1234, 3'b111, 0, 0, "R1");
        // R2 non-canonical addresses
        go(64'h0000_0800_0000_0000, 3'b001, 2'd0, 1'b0, 3'd1, 64'h0, 3'b000, 0, 0, "R2");
        go(64'h8000_0000_0000_0000, 3'b001, 2'd0, 1'b0, 3'd1, 64'h0, 3'b000, 0, 0, "R2");
        // R3 superpage window
        go(64'hFFFF_FC00_0000_0000 | 64'h0000_0100_0000_0000 | 64'h1234_5678, 3'b100, 2'd0, 1'b0,
           3'd0, 64'h0000_0800_1234_5678, 3'b111, 0, 0, "R3");
        go(64'hFFFF_FC00_1234_5678, 3'b001, 2'd0, 1'b0, 3'd0, 64'h0000_0000_1234_5678, 3'b111, 0, 0, "R3");
        go(64'hFFFF_FC00_1234_5678, 3'b001, 2'd1, 1'b0, 3'd1, 64'h0, 3'b000, 0, 0, "R3");
        // R3 negative canonical outside the window walks (level-1 index 0x300, empty)
        @(posedge clk); #1;
        issue_now(64'hFFFF_FE00_0000_0000, 3'b001, 2'd0, 1'b0, 3'd2, 64'h0, 3'b000, 1,
                  PTB + 64'h300 * 8, 0, 0, "R3");
        wait_empty();

        // R4 full walk, kernel read
        go(mkva(3, 5, 7, 'h123), 3'b001, 2'd0, 1'b0, 3'd0, (64'h1234 << 13) | 64'h123, 3'b111, 3,
           L3B + 64'd56, "R4");
        // R7 user mode rights by shifted bits
        go(mkva(3, 5, 8, 'h10), 3'b010, 2'd3, 1'b0, 3'd0, (64'h2000 << 13) | 64'h10, 3'b111, 3,
           L3B + 64'd64, "R7");
        go(mkva(3, 5, 8, 0), 3'b001, 2'd0, 1'b0, 3'd1, 64'h0, 3'b000, 3, L3B + 64'd64, "R7");
        go(mkva(3, 5, 7, 0), 3'b001, 2'd3, 1'b0, 3'd1, 64'h0, 3'b000, 3, L3B + 64'd56, "R7");
        go(mkva(3, 5, 12, 5), 3'b001, 2'd2, 1'b0, 3'd0, (64'h2003 << 13) | 64'h5, 3'b101, 3,
           L3B + 64'd96, "R7");
        go(mkva(3, 5, 12, 5), 3'b010, 2'd2, 1'b0, 3'd1, 64'h0, 3'b000, 3, L3B + 64'd96, "R7");
        // R8 fault-on codes and priority
        go(mkva(3, 5, 9, 0), 3'b100, 2'd0, 1'b0, 3'd5, 64'h0, 3'b000, 3, L3B + 64'd72, "R8");
        go(mkva(3, 5, 9, 0), 3'b010, 2'd0, 1'b0, 3'd4, 64'h0, 3'b000, 3, L3B + 64'd72, "R8");
        go(mkva(3, 5, 9, 0), 3'b001, 2'd0, 1'b0, 3'd3, 64'h0, 3'b000, 3, L3B + 64'd72, "R8");
        go(mkva(3, 5, 10, 0), 3'b110, 2'd0, 1'b0, 3'd0, 64'h2002 << 13, 3'b011, 3, L3B + 64'd80, "R8");
        go(mkva(3, 5, 10, 0), 3'b100, 2'd0, 1'b0, 3'd5, 64'h0, 3'b000, 3, L3B + 64'd80, "R8");
        // R9 empty need
        go(mkva(3, 5, 9, 7), 3'b000, 2'd0, 1'b0, 3'd0, (64'h2001 << 13) | 64'h7, 3'b000, 3,
           L3B + 64'd72, "R9");
        go(mkva(3, 5, 8, 0), 3'b000, 2'd0, 1'b0, 3'd0, 64'h2000 << 13, 3'b000, 3, L3B + 64'd64, "R9");
        // R5 invalid entries at each level
        go(mkva(3, 5, 11, 0), 3'b001, 2'd0, 1'b0, 3'd2, 64'h0, 3'b000, 3, L3B + 64'd88, "R5");
        @(posedge clk); #1;
        issue_now(mkva(3, 6, 0, 0), 3'b001, 2'd0, 1'b0, 3'd2, 64'h0, 3'b000, 2,
                  PTB + 64'd24, L2B + 64'd48, 0, "R5");
        wait_empty();
        @(posedge clk); #1;
        issue_now(mkva(4, 0, 0, 0), 3'b001, 2'd0, 1'b0, 3'd2, 64'h0, 3'b000, 1,
                  PTB + 64'd32, 0, 0, "R5");
        wait_empty();
        // R6 missing kernel read at upper levels
        @(posedge clk); #1;
        issue_now(mkva(5, 0, 0, 0), 3'b001, 2'd3, 1'b0, 3'd1, 64'h0, 3'b000, 1,
                  PTB + 64'd40, 0, 0, "R6");
        wait_empty();
        @(posedge clk); #1;
        issue_now(mkva(3, 7, 0, 0), 3'b001, 2'd0, 1'b0, 3'd1, 64'h0, 3'b000, 2,
                  PTB + 64'd24, L2B + 64'd56, 0, "R6");
        wait_empty();

        // R11 back to back: walk, superpage, walk, each started in a done cycle
        @(posedge clk); #1;
        issue_now(mkva(3, 5, 7, 1), 3'b001, 2'd0, 1'b0, 3'd0, (64'h1234 << 13) | 64'h1, 3'b111, 3,
                  PTB + 64'd24, L2B + 64'd40, L3B + 64'd56, "R11");
        wait_done();
        issue_now(64'hFFFF_FC00_0000_0040, 3'b001, 2'd0, 1'b0, 3'd0, 64'h40, 3'b111, 0, 0, 0, 0, "R11");
        wait_done();
        issue_now(mkva(3, 5, 8, 2), 3'b010, 2'd3, 1'b0, 3'd0, (64'h2000 << 13) | 64'h2, 3'b111, 3,
                  PTB + 64'd24, L2B + 64'd40, L3B + 64'd64, "R11");
        wait_empty();
        chk(exp_q.size() == 0, "R11", "all back-to-back results seen", 64'(exp_q.size()), 64'h0);

        // R10 request while busy is ignored
        @(posedge clk); #1;
        exp_q.push_back('{code: 3'd0, pa: (64'h1234 << 13) | 64'h9, prot: 3'b111, nr: 3,
                          a0: PTB + 64'd24, a1: L2B + 64'd40, a2: L3B + 64'd56, tag: "R10"});
        req_vaddr = mkva(3, 5, 7, 9); req_need = 3'b001; req_mode = 2'd0; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        req_vaddr = 64'h55; req_bypass = 1'b1; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0; req_bypass = 1'b0;
        wait_empty();
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0 && rd_log.size() == 0, "R10", "no extra result or read after ignored request",
            64'(rd_log.size()), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule